// File: doc/BRIEF.md
# Left-Justifying Serial Receive Word FIFO

This block sits between a serial receive shift register and the core or DMA that drains received data. Each time the shift register completes a word, the serial side presents all 24 bits with a valid strobe. The block keeps the upper one, two or three bytes of that word, as the current word-length mode selects. It left-justifies them, clears the unused low bytes and stores the result in a ten-entry queue. The consumer reads from the head of the queue through a valid/ready port, in the same cycles that the serial side keeps loading.

The write port follows valid/ready, with one difference: the shift register cannot be stalled. `sr_ready` drops whenever ten words are stored, and it does not depend on a read in the same cycle. A word offered while `sr_ready` is low is discarded, and a sticky overrun flag is set. On the read port, `out_valid` is the receive-not-empty flag. `out_data` shows the head word whenever `out_valid` is high, and a word leaves the queue on a cycle where both `out_valid` and `out_ready` are high. Two synchronous inputs empty the queue: `soft_clr`, which covers software reset and the block's own reset, and `stop_mode`. Hardware reset `rst_n` is asynchronous and empties it too.

Top module: `rx_word_fifo`

## Requirements
- R1: The queue holds 10 words of 24 bits. `full` goes high, and `sr_ready` goes low, in the cycle after the tenth stored word is accepted.
- R2: With `mode` = 2'b00 (8-bit), a stored word is `sr_data[23:16]` in bits 23:16, and bits 15:0 are zero.
- R3: With `mode` = 2'b01 (16-bit), a stored word is `sr_data[23:8]` in bits 23:8, and bits 7:0 are zero.
- R4: With `mode` = 2'b10 or 2'b11 (24-bit), all 24 bits of `sr_data` are stored unchanged.
- R5: Words are read out in the order they were accepted. This holds across any number of passes through the ten storage slots, since the slot index wraps from 9 back to 0.
- R6: When a word is accepted and a word is read in the same cycle, both take effect and the stored count stays the same.
- R7: `out_valid` stays high until every stored word has been read, and it falls in the cycle after the last one leaves.
- R8: A word offered while `full` is high is dropped. The stored words and their order are unchanged, and `overrun` is set in the next cycle.
- R9: `overrun` stays set until a cycle with `ovr_clr` high clears it. If a new overrun occurs in the same cycle as `ovr_clr`, the flag stays set.
- R10: Asynchronous `rst_n` low, a cycle with `soft_clr` high, or a cycle with `stop_mode` high empties the queue and clears `overrun`. Writes and reads offered in that cycle are ignored.
- R11: Asserting `out_ready` while `out_valid` is low has no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_clr | input | 1 | Synchronous flush for software reset and the block's own reset |
| stop_mode | input | 1 | Stop mode; each cycle it is high, the queue is flushed |
| mode | input | 2 | Word length: 00 = 8-bit, 01 = 16-bit, 10 or 11 = 24-bit |
| sr_valid | input | 1 | Shift register has completed a word |
| sr_data | input | 24 | Completed shift register contents |
| sr_ready | output | 1 | Queue can accept a word (not full) |
| out_valid | output | 1 | Receive-not-empty; `out_data` holds the head word |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | 24 | Head word, left-justified and zero-filled |
| full | output | 1 | Ten words are stored |
| overrun | output | 1 | Sticky flag: a word was dropped because the queue was full |
| ovr_clr | input | 1 | Clears `overrun` |

## Verification
On every cycle, the assertions check the following: the count bound, the slot-index wrap, that the count holds on a simultaneous read and write, that a full-queue write is dropped and raises `overrun`, that the flag is sticky, that every flush form leaves the queue empty, and that `out_valid` persists until the queue drains. Only the bench scenarios can show the data itself. These are the byte-mode justification and zero fill for each mode, the ordering of words across slot wrap-around, that a dropped word never reaches the output, and that the queue works normally again after each kind of flush.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_WIDTH = 24;
  localparam int unsigned RXF_DEPTH = 10;

  typedef enum logic [1:0] {
    WL_8   = 2'b00,
    WL_16  = 2'b01,
    WL_24  = 2'b10,
    WL_24B = 2'b11
  } wlen_e;

  // number of upper bytes kept for a given word-length mode
  function automatic logic [1:0] kept_bytes(input wlen_e m);
    case (m)
      WL_8:    kept_bytes = 2'd1;
      WL_16:   kept_bytes = 2'd2;
      default: kept_bytes = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/rxf_justify.sv
module rxf_justify #(
  parameter int unsigned BYTES = 3
) (
  input  rxf_pkg::wlen_e       mode,
  input  logic [BYTES*8-1:0]   raw,
  output logic [BYTES*8-1:0]   aligned
);
  logic [1:0] nkeep;
  assign nkeep = rxf_pkg::kept_bytes(mode);

  // byte b (0 = least significant) is kept when it lies in the top nkeep bytes
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic keep;
    assign keep = (b + int'(nkeep)) >= BYTES;
    assign aligned[b*8 +: 8] = keep ? raw[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/rxf_ptr.sv
module rxf_ptr #(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (clr)     ptr <= '0;
    else if (adv)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && adv && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned DEPTH = 10,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int unsigned WIDTH = rxf_pkg::RXF_WIDTH,
  parameter int unsigned DEPTH = rxf_pkg::RXF_DEPTH,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             stop_mode,
  input  logic [1:0]       mode,
  input  logic             sr_valid,
  input  logic [WIDTH-1:0] sr_data,
  output logic             sr_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             full,
  output logic             overrun,
  input  logic             ovr_clr
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic          flush;
  logic          wr_fire, rd_fire, drop;
  logic [CW-1:0] count;
  logic [PW-1:0] wptr, rptr;
  logic [WIDTH-1:0] aligned;

  assign flush     = soft_clr | stop_mode;
  assign full      = (count == CNT_FULL);
  assign sr_ready  = ~full;
  assign out_valid = (count != '0);
  assign wr_fire   = sr_valid & sr_ready & ~flush;
  assign rd_fire   = out_ready & out_valid & ~flush;
  assign drop      = sr_valid & full & ~flush;

  rxf_justify #(.BYTES(WIDTH / 8)) u_justify (
    .mode    (rxf_pkg::wlen_e'(mode)),
    .raw     (sr_data),
    .aligned (aligned)
  );

  rxf_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk (clk), .rst_n (rst_n), .clr (flush), .adv (wr_fire), .ptr (wptr)
  );

  rxf_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk (clk), .rst_n (rst_n), .clr (flush), .adv (rd_fire), .ptr (rptr)
  );

  rxf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wptr),
    .wdata (aligned),
    .raddr (rptr),
    .rdata (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (flush)              count <= '0;
    else if (wr_fire && !rd_fire) count <= count + 1'b1;
    else if (rd_fire && !wr_fire) count <= count - 1'b1;
  end

  // set wins over clear; flush wins over both
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (flush)   overrun <= 1'b0;
    else if (drop)    overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

  p_rdwr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(count));

  p_valid_until_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !flush && !(rd_fire && !wr_fire && count == CW'(1))) |=> out_valid);

  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_valid && full && !flush) |=> (overrun && count == $past(count) - CW'($past(rd_fire))));

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr && !flush) |=> overrun);

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !overrun && sr_ready));

  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !wr_fire) |=> !out_valid);
endmodule

// File: tb/rx_word_fifo_tb_top.sv
module rx_word_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 8;

  // {mode, shift register word, expected stored word}
  localparam logic [49:0] VEC [NVEC] = '{
    {2'b00, 24'hA5C3F1, 24'hA50000},
    {2'b01, 24'hA5C3F1, 24'hA5C300},
    {2'b10, 24'hA5C3F1, 24'hA5C3F1},
    {2'b11, 24'h123456, 24'h123456},
    {2'b00, 24'h00FFFF, 24'h000000},
    {2'b01, 24'hFF00FF, 24'hFF0000},
    {2'b10, 24'h000001, 24'h000001},
    {2'b00, 24'hFFFFFF, 24'hFF0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_clr = 1'b0, stop_mode = 1'b0, ovr_clr = 1'b0;
  logic [1:0] mode = 2'b10;
  logic sr_valid = 1'b0, out_ready = 1'b0;
  logic [23:0] sr_data = '0;
  logic sr_ready, out_valid, full, overrun;
  logic [23:0] out_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_word_fifo dut_i (
    .clk (clk), .rst_n (rst_n), .soft_clr (soft_clr), .stop_mode (stop_mode),
    .mode (mode), .sr_valid (sr_valid), .sr_data (sr_data), .sr_ready (sr_ready),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
    .full (full), .overrun (overrun), .ovr_clr (ovr_clr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] m, input logic [23:0] d);
    @(negedge clk);
    mode = m; sr_data = d; sr_valid = 1'b1;
    @(posedge clk); #1;
    sr_valid = 1'b0;
  endtask

  task automatic pop_chk(input logic [23:0] exp, input string req);
    @(negedge clk);
    chk(out_valid == 1'b1, req, {23'd0, out_valid}, 24'd1);
    chk(out_data == exp, req, out_data, exp);
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    logic [23:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state (R10)
    @(negedge clk);
    chk(!out_valid && !full && !overrun && sr_ready, "R10 reset state",
        {20'd0, out_valid, full, overrun, sr_ready}, 24'h1);

    // table walk: justification per mode (R2, R3, R4) and not-empty (R7)
    for (int i = 0; i < NVEC; i++) push(VEC[i][49:48], VEC[i][47:24]);
    for (int i = 0; i < NVEC; i++) pop_chk(VEC[i][23:0], mode_req(VEC[i][49:48]));
    @(negedge clk);
    chk(!out_valid, "R7 drained", {23'd0, out_valid}, 24'd0);

    // fill across the slot wrap (R1, R5)
    for (int i = 0; i < 10; i++) begin
      push(2'b10, 24'h111111 * (i + 1));
      @(negedge clk);
      if (i == 8) chk(!full && sr_ready, "R1 nine words", {23'd0, full}, 24'd0);
    end
    @(negedge clk);
    chk(full && !sr_ready, "R1 ten words full", {22'd0, full, sr_ready}, 24'h2);
    chk(!overrun, "R8 no overrun yet", {23'd0, overrun}, 24'd0);

    // overrun (R8)
    push(2'b10, 24'hDEADBE);
    @(negedge clk);
    chk(overrun, "R8 overrun set", {23'd0, overrun}, 24'd1);
    for (int i = 0; i < 10; i++) pop_chk(24'h111111 * (i + 1), "R5 order R8 drop");
    @(negedge clk);
    chk(!out_valid, "R8 dropped word absent", {23'd0, out_valid}, 24'd0);
    chk(overrun, "R9 sticky", {23'd0, overrun}, 24'd1);
    @(negedge clk); ovr_clr = 1'b1;
    @(posedge clk); #1; ovr_clr = 1'b0;
    @(negedge clk);
    chk(!overrun, "R9 cleared", {23'd0, overrun}, 24'd0);

    // simultaneous read and write (R6)
    push(2'b10, 24'h00000A);
    push(2'b10, 24'h00000B);
    push(2'b10, 24'h00000C);
    @(negedge clk);
    chk(out_data == 24'h00000A, "R6 head", out_data, 24'h00000A);
    sr_data = 24'h00000D; mode = 2'b10; sr_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1;
    sr_valid = 1'b0; out_ready = 1'b0;
    for (int i = 0; i < 7; i++) begin
      push(2'b10, 24'h0000E0 + i);
      @(negedge clk);
      if (i == 5) chk(!full, "R6 count held (not full at 9)", {23'd0, full}, 24'd0);
      if (i == 6) chk(full, "R6 count held (full at 10)", {23'd0, full}, 24'd1);
    end
    pop_chk(24'h00000B, "R6");
    pop_chk(24'h00000C, "R6");
    pop_chk(24'h00000D, "R6");
    for (int i = 0; i < 7; i++) pop_chk(24'h0000E0 + i, "R5 R6");

    // read while empty (R11)
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1; out_ready = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R11 empty read", {23'd0, out_valid}, 24'd0);
    push(2'b01, 24'h4321AB);
    pop_chk(24'h432100, "R11 R3");
    @(negedge clk);
    chk(!out_valid, "R11 single word drained", {23'd0, out_valid}, 24'd0);

    // soft flush with a full queue and overrun, write offered in the same cycle (R10)
    for (int i = 0; i < 11; i++) push(2'b10, 24'h500000 + i);
    @(negedge clk);
    soft_clr = 1'b1; sr_valid = 1'b1; sr_data = 24'h777777; out_ready = 1'b1;
    @(posedge clk); #1;
    soft_clr = 1'b0; sr_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    chk(!out_valid && !full && !overrun, "R10 soft flush",
        {21'd0, out_valid, full, overrun}, 24'd0);
    push(2'b10, 24'h2468AC);
    pop_chk(24'h2468AC, "R10 after soft flush");

    // stop mode flush (R10)
    push(2'b10, 24'h010203);
    push(2'b10, 24'h040506);
    @(negedge clk); stop_mode = 1'b1;
    @(posedge clk); #1; stop_mode = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R10 stop flush", {23'd0, out_valid}, 24'd0);

    // asynchronous reset (R10)
    push(2'b10, 24'h0A0B0C);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk(!out_valid && !full, "R10 async reset", {22'd0, out_valid, full}, 24'd0);
    @(negedge clk); rst_n = 1'b1;
    push(2'b00, 24'h9ABCDE);
    w = 24'h9A0000;
    pop_chk(w, "R10 R2 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule